// File: doc/BRIEF.md
# Configuration Address Translator

This block turns a CPU access that lands in the downstream configuration window into a standard type-0 style PCI configuration address. The device is not coded as a number in the window address: bits [31:11] of a 32-bit intermediate address form a one-hot select field, and the device number is the position of its least significant set bit. The lower half of the intermediate address is the low 16 bits of the window address. The upper half comes from a host mapping control word, and one bit of that word can block the whole window.

The translation itself is combinational. Every result is registered once and is presented with a valid strobe one cycle after the request. An accepted access, whether read or write, produces a configuration address with its enable bit set, plus a one-cycle pulse that the host uses to clear its received-master-abort and received-target-abort status bits. A rejected access produces no address. A rejected read also produces the all-ones data that the requester gets back, sized to the access width.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The device number placed in the output is the index, counting from zero, of the lowest set bit of bits [31:11] of the intermediate address {map_ctl[15:0], req_addr[15:0]}. Higher set bits have no effect.
- R2: An accepted access has these fields: bit 31 = 1, bits [30:24] = 0, bits [23:16] = bus_num, bits [15:11] = device number, bits [10:8] = req_addr[10:8], bits [7:2] = req_addr[7:2] and bits [1:0] = 0.
- R3: When map_ctl[16] is 1 the access is rejected: out_reject = 1 and cfg_addr = 0. A rejected access of any kind drives cfg_addr to 0.
- R4: A rejected read (req_write = 0) returns rej_rdata equal to all ones at the access width: 0x000000FF for a byte, 0x0000FFFF for a halfword and 0xFFFFFFFF for a word. An accepted access and any write return rej_rdata = 0.
- R5: req_size encodes 0 = byte, 1 = halfword, 2 = word, and 3 is also a word. A halfword with req_addr[0] = 1, or a word with req_addr[1:0] != 0, raises out_error and is rejected. A byte is never misaligned.
- R6: When bits [31:11] of the intermediate address are all zero, the access raises out_error and is rejected. A blocked access with a valid select field raises no error.
- R7: abort_clr is high for exactly the one result cycle of each accepted access, for reads and writes alike. It stays low for rejected accesses.
- R8: Results appear one clock after the request. out_valid is the request strobe delayed by one cycle. While out_valid is 0, out_accept, out_reject, out_error and abort_clr are 0. While out_valid is 1, exactly one of out_accept and out_reject is 1.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | 16 | Low half of the window address |
| map_ctl | input | 17 | Mapping control: [15:0] upper address half, [16] block |
| bus_num | input | 8 | Bus number placed in the output |
| out_valid | output | 1 | Result strobe |
| out_accept | output | 1 | Access translated |
| out_reject | output | 1 | Access refused |
| out_error | output | 1 | Misaligned or empty select field |
| abort_clr | output | 1 | Pulse to clear received-abort status |
| cfg_addr | output | 32 | Configuration address with enable bit |
| rej_rdata | output | 32 | Read data for a refused read |

## Verification
The assertions take the request fields to be stable only in the cycle where req_valid is high, and they relate each result to the request one cycle earlier. They therefore assume the requester never holds a request across cycles expecting one result. They also assume that map_ctl is sampled together with the address and not changed mid-access. The bench drives a fresh, complete request on each falling edge and reads the result on the next falling edge, so every request maps to exactly one result cycle. It sweeps every select-bit position, both halves of the intermediate address, all four size codes with every low-address offset, and both directions.

// File: rtl/cax_pkg.sv
package cax_pkg;

  localparam int CAX_CFG_W    = 32;
  localparam int CAX_EN_BIT   = 31;
  localparam int CAX_BUS_LSB  = 16;
  localparam int CAX_DEV_LSB  = 11;
  localparam int CAX_FN_LSB   = 8;
  localparam int CAX_FN_W     = 3;
  localparam int CAX_REG_LSB  = 2;
  localparam int CAX_REG_W    = 6;

  typedef enum logic [1:0] {
    CAX_BYTE  = 2'd0,
    CAX_HALF  = 2'd1,
    CAX_WORD  = 2'd2,
    CAX_WORD2 = 2'd3
  } cax_size_e;

  // All-ones pattern sized to the access width.
  function automatic logic [CAX_CFG_W-1:0] cax_fill(input cax_size_e sz);
    logic [CAX_CFG_W-1:0] v;
    case (sz)
      CAX_BYTE: v = 32'h0000_00FF;
      CAX_HALF: v = 32'h0000_FFFF;
      default:  v = 32'hFFFF_FFFF;
    endcase
    return v;
  endfunction

  // Alignment rule: halfword on even bytes, word on multiples of four.
  function automatic logic cax_misaligned(input cax_size_e sz, input logic [1:0] lo);
    logic m;
    case (sz)
      CAX_BYTE: m = 1'b0;
      CAX_HALF: m = lo[0];
      default:  m = |lo;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cax_field_decode.sv
module cax_field_decode
  import cax_pkg::*;
#(
  parameter int LO_W      = 16,
  parameter int IDSEL_LSB = 11,
  parameter int DEV_W     = 5
) (
  input  logic [LO_W-1:CAX_REG_LSB] addr_hi,
  input  logic [LO_W-1:0]           upper_half,
  output logic [DEV_W-1:0]          dev_num,
  output logic [CAX_FN_W-1:0]       fn_num,
  output logic [CAX_REG_W-1:0]      reg_num,
  output logic                      idsel_zero
);

  localparam int MID_W   = 2 * LO_W;
  localparam int IDSEL_W = MID_W - IDSEL_LSB;

  logic [MID_W-1:CAX_REG_LSB] mid;
  logic [IDSEL_W-1:0]         idsel;

  // Index of the least significant set bit; zero for an empty field.
  function automatic logic [DEV_W-1:0] lowest_one(input logic [IDSEL_W-1:0] v);
    logic [DEV_W-1:0] idx;
    idx = '0;
    for (int i = IDSEL_W - 1; i >= 0; i--) begin
      if (v[i]) idx = DEV_W'(i);
    end
    return idx;
  endfunction

  assign mid        = {upper_half, addr_hi};
  assign idsel      = mid[MID_W-1:IDSEL_LSB];
  assign idsel_zero = (idsel == '0);
  assign dev_num    = lowest_one(idsel);
  assign fn_num     = mid[CAX_FN_LSB +: CAX_FN_W];
  assign reg_num    = mid[CAX_REG_LSB +: CAX_REG_W];

endmodule

// File: rtl/cax_access_check.sv
module cax_access_check
  import cax_pkg::*;
(
  input  logic                 blocked,
  input  logic                 idsel_zero,
  input  logic                 is_write,
  input  logic [1:0]           size_code,
  input  logic [1:0]           addr_lo,
  output logic                 misaligned,
  output logic                 error,
  output logic                 reject,
  output logic [CAX_CFG_W-1:0] rd_fill
);

  cax_size_e sz;

  assign sz         = cax_size_e'(size_code);
  assign misaligned = cax_misaligned(sz, addr_lo);
  assign error      = misaligned | idsel_zero;
  assign reject     = error | blocked;
  assign rd_fill    = (reject && !is_write) ? cax_fill(sz) : '0;

endmodule

// File: rtl/cax_addr_pack.sv
module cax_addr_pack
  import cax_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5
) (
  input  logic [BUS_W-1:0]     bus,
  input  logic [DEV_W-1:0]     dev,
  input  logic [CAX_FN_W-1:0]  fn,
  input  logic [CAX_REG_W-1:0] regn,
  output logic [CAX_CFG_W-1:0] cfg
);

  always_comb begin
    cfg                             = '0;
    cfg[CAX_EN_BIT]                 = 1'b1;
    cfg[CAX_BUS_LSB +: BUS_W]       = bus;
    cfg[CAX_DEV_LSB +: DEV_W]       = dev;
    cfg[CAX_FN_LSB  +: CAX_FN_W]    = fn;
    cfg[CAX_REG_LSB +: CAX_REG_W]   = regn;
  end

endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cax_pkg::*;
#(
  parameter int LO_W      = 16,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int IDSEL_LSB = 11,
  parameter int BLOCK_BIT = LO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [LO_W-1:0]      req_addr,
  input  logic [BLOCK_BIT:0]   map_ctl,
  input  logic [BUS_W-1:0]     bus_num,
  output logic                 out_valid,
  output logic                 out_accept,
  output logic                 out_reject,
  output logic                 out_error,
  output logic                 abort_clr,
  output logic [CAX_CFG_W-1:0] cfg_addr,
  output logic [CAX_CFG_W-1:0] rej_rdata
);

  // Named internal events
  logic [DEV_W-1:0]     dec_dev;
  logic [CAX_FN_W-1:0]  dec_fn;
  logic [CAX_REG_W-1:0] dec_reg;
  logic                 dec_idsel_zero;
  logic                 chk_misaligned;
  logic                 chk_error;
  logic                 chk_reject;
  logic [CAX_CFG_W-1:0] chk_fill;
  logic [CAX_CFG_W-1:0] packed_addr;

  cax_field_decode #(
    .LO_W      (LO_W),
    .IDSEL_LSB (IDSEL_LSB),
    .DEV_W     (DEV_W)
  ) u_decode (
    .addr_hi    (req_addr[LO_W-1:CAX_REG_LSB]),
    .upper_half (map_ctl[LO_W-1:0]),
    .dev_num    (dec_dev),
    .fn_num     (dec_fn),
    .reg_num    (dec_reg),
    .idsel_zero (dec_idsel_zero)
  );

  cax_access_check u_check (
    .blocked    (map_ctl[BLOCK_BIT]),
    .idsel_zero (dec_idsel_zero),
    .is_write   (req_write),
    .size_code  (req_size),
    .addr_lo    (req_addr[1:0]),
    .misaligned (chk_misaligned),
    .error      (chk_error),
    .reject     (chk_reject),
    .rd_fill    (chk_fill)
  );

  cax_addr_pack #(
    .BUS_W (BUS_W),
    .DEV_W (DEV_W)
  ) u_pack (
    .bus  (bus_num),
    .dev  (dec_dev),
    .fn   (dec_fn),
    .regn (dec_reg),
    .cfg  (packed_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_reject <= 1'b0;
      out_error  <= 1'b0;
      abort_clr  <= 1'b0;
      cfg_addr   <= '0;
      rej_rdata  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_accept <= !chk_reject;
        out_reject <= chk_reject;
        out_error  <= chk_error;
        abort_clr  <= !chk_reject;
        cfg_addr   <= chk_reject ? '0 : packed_addr;
        rej_rdata  <= chk_fill;
      end else begin
        out_accept <= 1'b0;
        out_reject <= 1'b0;
        out_error  <= 1'b0;
        abort_clr  <= 1'b0;
        cfg_addr   <= '0;
        rej_rdata  <= '0;
      end
    end
  end

  logic unused_misaligned;
  assign unused_misaligned = chk_misaligned;

endmodule

// File: rtl/cax_checker.sv
module cax_checker #(
  parameter int LO_W      = 16,
  parameter int IDSEL_LSB = 11,
  parameter int BLOCK_BIT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [LO_W-1:0]    req_addr,
  input logic [BLOCK_BIT:0] map_ctl,
  input logic               out_valid,
  input logic               out_accept,
  input logic               out_reject,
  input logic               out_error,
  input logic               abort_clr,
  input logic [31:0]        cfg_addr,
  input logic [31:0]        rej_rdata,
  input logic               misaligned_evt
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_accept != out_reject)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_accept && !out_reject && !out_error && !abort_clr)); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R8
  AST_BLOCK_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_ctl[BLOCK_BIT]) |=> out_reject); // R3
  AST_REJECT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_reject |-> (cfg_addr == 32'd0)); // R3
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd1 && req_addr[0]) |=> (out_error && out_reject)); // R5
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size[1] && req_addr[1:0] != 2'd0) |=> (out_error && out_reject)); // R5
  AST_MISALIGN_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misaligned_evt) |=> out_error); // R5
  AST_IDSEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {map_ctl[LO_W-1:0], req_addr[LO_W-1:IDSEL_LSB]} == '0)
      |=> (out_error && out_reject)); // R6
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0 && cfg_addr[1:0] == 2'd0)); // R2
  AST_LOW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_ctl[BLOCK_BIT]) |=> (!out_accept || cfg_addr[10:2] == $past(req_addr[10:2]))); // R2
  AST_CLR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (abort_clr == out_accept)); // R7
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rej_rdata == 32'd0)); // R4
  AST_ACCEPT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> (rej_rdata == 32'd0)); // R4

endmodule

bind cfg_addr_xlate cax_checker #(
  .LO_W      (LO_W),
  .IDSEL_LSB (IDSEL_LSB),
  .BLOCK_BIT (BLOCK_BIT)
) u_cax_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .req_size       (req_size),
  .req_addr       (req_addr),
  .map_ctl        (map_ctl),
  .out_valid      (out_valid),
  .out_accept     (out_accept),
  .out_reject     (out_reject),
  .out_error      (out_error),
  .abort_clr      (abort_clr),
  .cfg_addr       (cfg_addr),
  .rej_rdata      (rej_rdata),
  .misaligned_evt (chk_misaligned)
);

// File: tb/cfg_addr_xlate_tb.sv
`timescale 1ns/1ps
module cfg_addr_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = 16'd0;
  logic [16:0] map_ctl = 17'd0;
  logic [7:0]  bus_num = 8'd0;
  logic        out_valid, out_accept, out_reject, out_error, abort_clr;
  logic [31:0] cfg_addr, rej_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_addr_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .map_ctl(map_ctl), .bus_num(bus_num),
    .out_valid(out_valid), .out_accept(out_accept), .out_reject(out_reject),
    .out_error(out_error), .abort_clr(abort_clr), .cfg_addr(cfg_addr),
    .rej_rdata(rej_rdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive one request at a falling edge; the result is read on the next falling edge.
  task automatic run_req(input bit wr, input int sz, input int addr, input int map, input int bus);
    longint mid, sel, dev, fn, rg, expa, fill;
    bit mis, empty, blk, rej;
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 2'(sz);
    req_addr  = 16'(addr);
    map_ctl   = 17'(map);
    bus_num   = 8'(bus);
    @(negedge clk);
    mid   = (longint'(map % 65536) * 65536) + longint'(addr);
    sel   = mid / 2048;
    dev   = 0;
    while (sel != 0 && (sel % 2) == 0) begin
      sel = sel / 2;
      dev = dev + 1;
    end
    fn    = (mid / 256) % 8;
    rg    = ((mid % 256) / 4) * 4;
    empty = (mid / 2048) == 0;
    mis   = (sz == 1 && (addr % 2) != 0) || (sz >= 2 && (addr % 4) != 0);
    blk   = (map / 65536) % 2 == 1;
    rej   = mis || empty || blk;
    expa  = rej ? 0 : (longint'(1) << 31) + longint'(bus) * 65536 + dev * 2048 + fn * 256 + rg;
    fill  = (sz == 0) ? 64'hFF : (sz == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
    if (!rej || wr) fill = 0;
    check("R8 valid", {31'd0, out_valid}, 32'd1);
    check("R3 reject", {31'd0, out_reject}, {31'd0, rej});
    check("R8 accept", {31'd0, out_accept}, {31'd0, !rej});
    check("R5/R6 error", {31'd0, out_error}, {31'd0, mis || empty});
    check("R7 abort_clr", {31'd0, abort_clr}, {31'd0, !rej});
    check("R1/R2 cfg_addr", cfg_addr, 32'(expa));
    check("R4 rej_rdata", rej_rdata, 32'(fill));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", {31'd0, out_valid}, 32'd0);
    check("R9 cfg_addr", cfg_addr, 32'd0);
    check("R9 rej_rdata", rej_rdata, 32'd0);
    check("R9 flags", {27'd0, out_accept, out_reject, out_error, abort_clr, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep select position x function x size x offset x direction (R1 R2 R4 R5 R7)
    for (int pos = 0; pos < 21; pos++) begin
      for (int fn = 0; fn < 8; fn++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int off = 0; off < 4; off++) begin
            for (int wr = 0; wr < 2; wr++) begin
              int addr, map, rg;
              rg = (n * 7) % 64;
              map = 0;
              addr = fn * 256 + rg * 4 + off;
              if (pos < 5) addr = addr + (1 << (pos + 11));
              else map = 1 << (pos - 5);
              // extra higher select bit must not change the device (R1)
              if ((fn % 2) == 1 && pos < 20) begin
                if (pos + 1 < 5) addr = addr | (1 << (pos + 12));
                else map = map | (1 << (pos - 4));
              end
              run_req(wr[0], sz, addr, map, (n * 37) % 256);
              n++;
            end
          end
        end
      end
    end

    // R3: block bit with a valid select field, reads and writes, every width
    for (int sz = 0; sz < 4; sz++) begin
      run_req(1'b0, sz, 16'h0800, 17'h1_0004, 8'h5A);
      run_req(1'b1, sz, 16'h0800, 17'h1_0004, 8'h5A);
    end
    // R6: empty select field, aligned, both directions
    for (int sz = 0; sz < 3; sz++) begin
      run_req(1'b0, sz, 16'h07FC, 17'h0_0000, 8'h11);
      run_req(1'b1, sz, 16'h0700, 17'h0_0000, 8'h11);
    end
    // R6 with block bit: both refusals together
    run_req(1'b0, 2, 16'h0000, 17'h1_0000, 8'h22);

    // R8: an idle cycle yields no result
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 idle valid", {31'd0, out_valid}, 32'd0);
    check("R8 idle flags", {28'd0, out_accept, out_reject, out_error, abort_clr}, 32'd0);
    check("R7 idle abort_clr", {31'd0, abort_clr}, 32'd0);

    // R2: full bus range in the output on one accepted word read
    for (int b = 0; b < 256; b += 51) run_req(1'b0, 2, 16'hF7FC, 17'h0_8001, b);

    req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule